// File: doc/BRIEF.md
# Time-Division Serial Channel Slave

This block attaches to a 2048 kbit/s time-division serial bus. The bus is clocked at 4096 kHz, so each bit cell lasts two clock periods. A frame holds 32 channels of eight bits and repeats every 125 µs. An active-low frame pulse, one clock wide, marks the start of each frame. The block counts clocks from that pulse. It captures the first four channels of the input stream into parallel byte registers and drives the output stream only in its own enabled slots.

Channel 1 carries a control byte. The host writes that byte into a holding buffer at any moment, and the buffer is moved into the transmit register at each frame start. Channels 2 and 3 are voice channels, and each has its own enable. Channel 0 is received but never driven. Whenever the block does not drive the line, it pulls its output enable low so that the pad can float.

Top module: `tdm_chan_if`

## Requirements
- R1: A frame spans 512 clocks and then wraps. In the cycle that lies k clocks after a frame start, the active channel is k/16 and the bit index within that channel is (k mod 16)/2, with index 0 sent first.
- R2: A clock edge that samples the frame pulse low restarts the timing. The next cycle becomes cycle 0 of channel 0, whatever the previous alignment was.
- R3: The output enable is low in channel 0, in every channel from 4 to 31, and in any of channels 1 to 3 whose enable is clear. Wherever the enable is low, the serial output is 0.
- R4: Data goes out MSB first. Bit index b of an enabled slot carries bit 7-b of that slot's transmit byte.
- R5: The control byte is double-buffered. A host write changes the channel 1 transmit byte only at the next frame start. A write that falls on the frame-start edge itself is sent in the frame that starts on that edge.
- R6: When their enables are set, channels 2 and 3 send the voice A and voice B transmit bytes. Those bytes are sampled at the frame start, and later changes within the frame have no effect until the next frame.
- R7: The input is sampled at the middle of each bit cell, on the edge that ends the first clock of the cell, and bits arrive MSB first. Byte n of the receive bus, at bits 8n+7:8n, is updated at the final sample of channel n. Channel 0 is always captured.
- R8: The receive bytes for channels 1, 2 and 3 change only while the matching enable (control, voice A, voice B) is set. Otherwise they hold their previous value.
- R9: After reset, all receive bytes and the control buffer are zero, and the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 4096 kHz bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| framePulseN | input | 1 | Active-low frame pulse, one clock wide |
| serIn | input | 1 | Serial input stream |
| hostWr | input | 1 | One-cycle strobe that writes the control buffer |
| hostData | input | 8 | Control byte to transmit |
| ctrlEn | input | 1 | Enables channel 1 (control) |
| voiceEnA | input | 1 | Enables channel 2 (voice A) |
| voiceEnB | input | 1 | Enables channel 3 (voice B) |
| voiceTxA | input | 8 | Transmit byte for channel 2 |
| voiceTxB | input | 8 | Transmit byte for channel 3 |
| serOut | output | 1 | Serial output stream |
| serOutEn | output | 1 | Output enable for the pad driver; low means the pad floats |
| rxBytes | output | 32 | Received channels 0 to 3, byte n at bits 8n+7:8n |

## Verification
A host write and a frame start can fall on the same clock edge. In that case the buffer load and the transfer to the transmit register compete for the same byte. The bench provokes this on purpose by raising the write strobe in the same cycle as the frame pulse. It then requires the new byte to appear in the channel 1 slot of the frame that begins on that edge. Other writes are placed in the middle of a frame, including inside the channel 1 slot itself. For these the bench requires the old byte to finish its slot and the new byte to appear only in the following frame.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  parameter int CLK_PER_BIT = 2;
  parameter int BITS        = 8;
  parameter int CHANNELS    = 32;
  parameter int USED        = 4;

  localparam int HALF_W     = $clog2(CLK_PER_BIT);
  localparam int BIT_W      = $clog2(BITS);
  localparam int CH_W       = $clog2(CHANNELS);
  localparam int USED_W     = $clog2(USED);
  localparam int CNT_W      = HALF_W + BIT_W + CH_W;
  localparam int FRAME_CLKS = CLK_PER_BIT * BITS * CHANNELS;

  // strobes from the timing control to the datapath
  typedef struct packed {
    logic              frameStart;
    logic              sample;
    logic              rxLoad;
    logic              outEn;
    logic [CH_W-1:0]   chan;
    logic [BIT_W-1:0]  bitIdx;
  } tdm_strobe_t;
endpackage

// File: rtl/tdm_ctrl.sv
module tdm_ctrl
  import tdm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        framePulseN,
  input  logic        ctrlEn,
  input  logic        voiceEnA,
  input  logic        voiceEnB,
  output tdm_strobe_t strb
);
  localparam logic [CNT_W-1:0]  LAST_CNT  = CNT_W'(FRAME_CLKS - 1);
  localparam logic [HALF_W-1:0] MID_PHASE = HALF_W'(CLK_PER_BIT / 2 - 1);
  localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(BITS - 1);

  logic [CNT_W-1:0]  cnt;
  logic [HALF_W-1:0] phase;
  logic [BIT_W-1:0]  bitIdx;
  logic [CH_W-1:0]   chan;
  logic [USED-1:0]   enVec;
  logic              slotHit;
  logic [USED_W-1:0] chanSel;

  // clock count within the frame; the frame pulse forces a restart
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cnt <= '0;
    else if (!framePulseN) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  assign phase   = cnt[HALF_W-1:0];
  assign bitIdx  = cnt[HALF_W +: BIT_W];
  assign chan    = cnt[HALF_W+BIT_W +: CH_W];
  assign slotHit = chan < CH_W'(USED);
  assign chanSel = chan[USED_W-1:0];

  // channel 0 is receive-only; 1 control; 2 and 3 voice
  assign enVec = {voiceEnB, voiceEnA, ctrlEn, 1'b0};

  always_comb begin
    strb            = '0;
    strb.chan       = chan;
    strb.bitIdx     = bitIdx;
    strb.frameStart = !framePulseN || (cnt == LAST_CNT);
    strb.sample     = (phase == MID_PHASE);
    strb.outEn      = slotHit && enVec[chanSel];
    strb.rxLoad     = strb.sample && slotHit && (bitIdx == LAST_BIT) &&
                      ((chanSel == '0) || enVec[chanSel]);
  end

  p_resync_r2: assert property (@(posedge clk) disable iff (!rstN)
    !framePulseN |=> (cnt == '0));

  p_step_r1: assert property (@(posedge clk) disable iff (!rstN)
    framePulseN |=> (cnt == $past(cnt) + CNT_W'(1)));
endmodule

// File: rtl/tdm_datapath.sv
module tdm_datapath
  import tdm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  tdm_strobe_t          strb,
  input  logic                 serIn,
  input  logic                 hostWr,
  input  logic [BITS-1:0]      hostData,
  input  logic [BITS-1:0]      voiceTxA,
  input  logic [BITS-1:0]      voiceTxB,
  output logic                 serOut,
  output logic                 serOutEn,
  output logic [USED*BITS-1:0] rxBytes
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BITS - 1);

  logic [BITS-1:0]                hostBuf;
  logic [USED-1:0][BITS-1:0]      txBytes;
  logic [USED-1:0][BITS-1:0]      rxRegs;
  logic [BITS-1:0]                rxShift;
  logic [BITS-1:0]                rxNext;
  logic [USED_W-1:0]              chanSel;

  assign chanSel = strb.chan[USED_W-1:0];
  assign rxNext  = {rxShift[BITS-2:0], serIn};

  // host holding buffer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       hostBuf <= '0;
    else if (hostWr) hostBuf <= hostData;
  end

  // transmit bytes taken at frame start; a write on that edge bypasses
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBytes <= '0;
    end else if (strb.frameStart) begin
      txBytes[0] <= '0;
      txBytes[1] <= hostWr ? hostData : hostBuf;
      txBytes[2] <= voiceTxA;
      txBytes[3] <= voiceTxB;
    end
  end

  // receive shift and per-channel capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      rxRegs  <= '0;
    end else if (strb.sample) begin
      rxShift <= rxNext;
      if (strb.rxLoad) rxRegs[chanSel] <= rxNext;
    end
  end

  assign rxBytes  = rxRegs;
  assign serOutEn = strb.outEn;
  assign serOut   = strb.outEn ? txBytes[chanSel][LAST_BIT - strb.bitIdx] : 1'b0;

  p_quiet_slots_r3: assert property (@(posedge clk) disable iff (!rstN)
    ((strb.chan >= CH_W'(USED)) || (strb.chan == '0)) |-> (!serOutEn && !serOut));

  p_ctrl_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.frameStart |=> $stable(txBytes[1]));

  p_rx_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rxLoad |=> $stable(rxRegs));
endmodule

// File: rtl/tdm_chan_if.sv
module tdm_chan_if
  import tdm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 framePulseN,
  input  logic                 serIn,
  input  logic                 hostWr,
  input  logic [BITS-1:0]      hostData,
  input  logic                 ctrlEn,
  input  logic                 voiceEnA,
  input  logic                 voiceEnB,
  input  logic [BITS-1:0]      voiceTxA,
  input  logic [BITS-1:0]      voiceTxB,
  output logic                 serOut,
  output logic                 serOutEn,
  output logic [USED*BITS-1:0] rxBytes
);
  tdm_strobe_t strb;

  tdm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .framePulseN(framePulseN),
    .ctrlEn(ctrlEn), .voiceEnA(voiceEnA), .voiceEnB(voiceEnB),
    .strb(strb)
  );

  tdm_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .serIn(serIn),
    .hostWr(hostWr), .hostData(hostData),
    .voiceTxA(voiceTxA), .voiceTxB(voiceTxB),
    .serOut(serOut), .serOutEn(serOutEn), .rxBytes(rxBytes)
  );
endmodule

// File: tb/tdm_chan_if_tb.sv
module tdm_chan_if_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rstN = 0, framePulseN = 1, serIn = 0;
  logic        hostWr = 0, ctrlEn = 0, voiceEnA = 0, voiceEnB = 0;
  logic [7:0]  hostData = 0, voiceTxA = 0, voiceTxB = 0;
  logic        serOut, serOutEn;
  logic [31:0] rxBytes;

  int checks = 0, errors = 0;
  logic [7:0] bufModel = 0;
  logic [7:0] rxModel [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  tdm_chan_if u_dut (
    .clk(clk), .rstN(rstN), .framePulseN(framePulseN), .serIn(serIn),
    .hostWr(hostWr), .hostData(hostData), .ctrlEn(ctrlEn),
    .voiceEnA(voiceEnA), .voiceEnB(voiceEnB),
    .voiceTxA(voiceTxA), .voiceTxB(voiceTxB),
    .serOut(serOut), .serOutEn(serOutEn), .rxBytes(rxBytes)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit slotOn(input int ch, input bit c, input bit a, input bit b);
    return (ch == 1 && c) || (ch == 2 && a) || (ch == 3 && b);
  endfunction

  function automatic bit msbBit(input logic [7:0] v, input int idx);
    return v[7 - idx];
  endfunction

  // wrCycle: -1 none, -2 on the frame-start edge, else cycle of the write
  task automatic runFrame(input int wrCycle, input logic [7:0] wrData,
                          input int voiceCycle, input int gap);
    logic [7:0] inB [32];
    logic [7:0] txExp [4];
    for (int i = 0; i < 32; i++) inB[i] = 8'($urandom);
    repeat (gap) @(negedge clk);
    @(negedge clk);
    framePulseN = 0;
    hostWr = 0;
    if (wrCycle == -2) begin
      hostWr = 1; hostData = wrData;
      bufModel = wrData;
    end
    txExp[0] = 0; txExp[1] = bufModel; txExp[2] = voiceTxA; txExp[3] = voiceTxB;
    @(posedge clk);
    for (int c = 0; c < 512; c++) begin
      int ch, bi;
      bit expEn, expBit;
      @(negedge clk);
      framePulseN = 1;
      hostWr = 0;
      ch = c / 16; bi = (c % 16) / 2;
      serIn = msbBit(inB[ch], bi);
      if (c == wrCycle) begin hostWr = 1; hostData = wrData; end
      if (c == voiceCycle) begin voiceTxA = 8'($urandom); voiceTxB = 8'($urandom); end
      expEn  = (ch < 4) && slotOn(ch, ctrlEn, voiceEnA, voiceEnB);
      expBit = expEn ? msbBit(txExp[ch], bi) : 1'b0;
      // R3 enable per slot; R4/R5/R6 bit content; R1/R2 slot timing
      if (!(serOutEn === expEn && serOut === expBit)) begin
        check(0, ch == 1 ? "R5 R4 R1" : (ch >= 2 && ch < 4) ? "R6 R4 R2" : "R3",
              {serOutEn, serOut}, {expEn, expBit});
      end else checks++;
    end
    if (wrCycle >= 0) bufModel = wrData;
    // R7 capture and R8 hold
    rxModel[0] = inB[0];
    if (ctrlEn)   rxModel[1] = inB[1];
    if (voiceEnA) rxModel[2] = inB[2];
    if (voiceEnB) rxModel[3] = inB[3];
    for (int n = 0; n < 4; n++)
      check(rxBytes[8*n +: 8] === rxModel[n], n == 0 ? "R7 ch0" : "R8 R7 rx",
            rxBytes[8*n +: 8], rxModel[n]);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int n = 0; n < 4; n++) rxModel[n] = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R9 reset state
    check(rxBytes === 32'h0, "R9 rx reset", rxBytes, 0);
    check(serOutEn === 1'b0, "R9 oe reset", serOutEn, 0);

    // R9 control buffer starts at zero: first frame sends 0x00 in channel 1
    ctrlEn = 1; voiceEnA = 0; voiceEnB = 0;
    runFrame(-1, 8'h00, -1, 0);

    // R5 write inside the channel 1 slot: old byte finishes, new next frame
    runFrame(20, 8'hA5, -1, 0);
    runFrame(-1, 8'h00, -1, 3);

    // R5 collision: write on the frame-start edge goes out at once
    runFrame(-2, 8'h3C, -1, 0);

    // R6 voice bytes changed mid-frame are not sent until next frame
    voiceEnA = 1; voiceEnB = 1;
    voiceTxA = 8'h81; voiceTxB = 8'h7E;
    runFrame(-1, 8'h00, 40, 0);

    // R3 R8 all disabled: output floats everywhere, rx 1..3 hold
    ctrlEn = 0; voiceEnA = 0; voiceEnB = 0;
    runFrame(100, 8'hC3, -1, 5);

    // random frames, R2 realignment through gaps
    for (int f = 0; f < 16; f++) begin
      int sel, wc;
      ctrlEn   = 1'($urandom);
      voiceEnA = 1'($urandom);
      voiceEnB = 1'($urandom);
      voiceTxA = 8'($urandom);
      voiceTxB = 8'($urandom);
      sel = $urandom_range(0, 3);
      wc  = (sel == 0) ? -1 : (sel == 1) ? -2 : $urandom_range(0, 500);
      runFrame(wc, 8'($urandom), $urandom_range(0, 500), $urandom_range(0, 12));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule